// File: doc/BRIEF.md
# Dual-Mode Register State Controller

This block keeps the architectural register state of a 16-bit processor core that can also run in an 8-bit compatibility (emulation) mode. It holds a 16-bit accumulator, two 16-bit index registers (X and Y), a 16-bit stack pointer, an 8-bit program bank, an 8-bit data bank, and the status flags C, M, X and E. The decoder and sequencer of the core drive it with single-cycle command strobes, and the block applies every side effect the mode rules call for. Those side effects include forced register bytes on mode entry, status writes masked by mode, and bank clearing on interrupt entry.

The status byte layout is fixed: C is bit 0, X is bit 4 and M is bit 5. The same operand byte carries the flag mask for clear/set commands and the pulled value for a status pull. The block also drives the two-bit MX status output with a qualifier that marks the cycle after a status update as unreliable. For interrupt entry in native mode, it drives a one-cycle push request that carries the program bank value the interrupt replaced.

Top module: `dual_mode_regstate`

## Requirements
- R1: After reset: E=1, M=1, X=1, C=0, accumulator=0x0000, X=Y=0x0000, stack pointer=0x01FF, both banks=0x00, mx_valid=1, push_req=0.
- R2: An exchange command (xce_cmd) swaps C and E on the next clock edge.
- R3: When an exchange moves E from 0 to 1: M and X become 1, the stack high byte becomes 0x01, and the X and Y high bytes become 0x00. The low bytes of S, X and Y and both accumulator bytes are unchanged.
- R4: When an exchange moves E from 1 to 0, only C and E change. M, X and all registers keep their values.
- R5: In native mode (E=0), rep_cmd clears and sep_cmd sets each of M (bit 5), X (bit 4) and C (bit 0) whose bit is 1 in stat_opnd. The other flags keep their values.
- R6: In emulation mode (E=1), rep_cmd, sep_cmd and plp_cmd leave M and X at 1. C is still updated from bit 0.
- R7: In native mode, plp_cmd loads M, X and C from stat_opnd bits 5, 4 and 0.
- R8: mx_bits equals {M, X} at all times. mx_valid is 0 for exactly the one cycle after an accepted rep_cmd, sep_cmd or plp_cmd, and 1 otherwise.
- R9: In native mode, int_cmd clears the program bank. In the next cycle, push_req is 1 for one cycle and push_data holds the old program bank. The data bank is unchanged.
- R10: In emulation mode, int_cmd clears both the program bank and the data bank, and push_req stays 0.
- R11: A write (wr_en) loads the register chosen by wr_sel (0=A, 1=X, 2=Y, 3=S, 4=program bank, 5=data bank, 6 and 7 = no register) from wr_data. Banks take the low byte. The X and Y high bytes are forced to 0x00 while flag X is 1. The stack high byte is forced to 0x01 while E is 1.
- R12: When several strobes arrive in one cycle, only one takes effect, in the priority int_cmd, xce_cmd, rep_cmd, sep_cmd, plp_cmd, wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_cmd | input | 1 | Interrupt entry strobe (hardware, BRK or COP) |
| xce_cmd | input | 1 | Exchange carry with emulation flag |
| rep_cmd | input | 1 | Clear status flags selected by stat_opnd |
| sep_cmd | input | 1 | Set status flags selected by stat_opnd |
| plp_cmd | input | 1 | Load status flags from stat_opnd |
| stat_opnd | input | 8 | Status mask or pulled status byte |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 16 | Write data |
| a_q | output | 16 | Accumulator |
| x_q | output | 16 | X index register |
| y_q | output | 16 | Y index register |
| s_q | output | 16 | Stack pointer |
| pbr_q | output | 8 | Program bank |
| dbr_q | output | 8 | Data bank |
| flag_c | output | 1 | Carry flag |
| flag_m | output | 1 | Accumulator width flag M |
| flag_x | output | 1 | Index width flag X |
| flag_e | output | 1 | Emulation flag |
| mx_bits | output | 2 | MX status output {M, X} |
| mx_valid | output | 1 | MX output qualifier |
| push_req | output | 1 | Request to push the saved program bank |
| push_data | output | 8 | Program bank value to push |

## Verification
The assertions check on every cycle the invariants that emulation mode imposes: M and X at 1, stack page 0x01, and clear index high bytes. They also check the carry and emulation swap, the one-cycle drop of mx_valid after a status command, and the pairing of push_req with a native interrupt and the old bank value. Some properties depend on a chosen history, and only the bench scenarios can show them. These are the preserved low bytes across a mode change, the masked flag updates, the priority among colliding strobes, and the forced high bytes on writes. The bench checks them against a reference model driven by directed sequences and seeded random commands.

// File: rtl/rsc_pkg.sv
// Shared types for the dual-mode register state controller.
// Assumes: status byte layout C=bit0, X=bit4, M=bit5.
package rsc_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_INT  = 3'd1,
        OP_XCE  = 3'd2,
        OP_REP  = 3'd3,
        OP_SEP  = 3'd4,
        OP_PLP  = 3'd5,
        OP_WR   = 3'd6
    } op_e;

    localparam int BIT_C = 0;
    localparam int BIT_X = 4;
    localparam int BIT_M = 5;

    localparam logic [2:0] SEL_A  = 3'd0;
    localparam logic [2:0] SEL_X  = 3'd1;
    localparam logic [2:0] SEL_Y  = 3'd2;
    localparam logic [2:0] SEL_S  = 3'd3;
    localparam logic [2:0] SEL_PB = 3'd4;
    localparam logic [2:0] SEL_DB = 3'd5;
endpackage

// File: rtl/rsc_cmd_decode.sv
// Command arbiter: picks the single command that takes effect this cycle.
// Assumes: strobes are single-cycle; fixed priority int > xce > rep > sep > plp > wr.
module rsc_cmd_decode
    import rsc_pkg::*;
(
    input  logic int_cmd,
    input  logic xce_cmd,
    input  logic rep_cmd,
    input  logic sep_cmd,
    input  logic plp_cmd,
    input  logic wr_en,
    output op_e  op
);
    // Fixed-priority selection of the active command.
    always_comb begin
        if (int_cmd)      op = OP_INT;
        else if (xce_cmd) op = OP_XCE;
        else if (rep_cmd) op = OP_REP;
        else if (sep_cmd) op = OP_SEP;
        else if (plp_cmd) op = OP_PLP;
        else if (wr_en)   op = OP_WR;
        else              op = OP_NONE;
    end
endmodule

// File: rtl/rsc_status.sv
// Status flag unit: holds C, M, X, E and the MX qualifier.
// Assumes: op is already arbitrated; emulation mode pins M and X to 1.
module rsc_status
    import rsc_pkg::*;
#(
    parameter int SB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_e             op,
    input  logic [SB_W-1:0] opnd,
    output logic            c_q,
    output logic            m_q,
    output logic            x_q,
    output logic            e_q,
    output logic            enter_emu,
    output logic            mx_valid
);
    logic upd_q;
    logic unused_opnd;

    assign unused_opnd = ^{opnd[SB_W-1:BIT_M+1], opnd[BIT_X-1:BIT_C+1]};

    // Exchange that takes the core from native into emulation mode.
    assign enter_emu = (op == OP_XCE) && !e_q && c_q;

    // Flag register updates per command and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            m_q <= 1'b1;
            x_q <= 1'b1;
            e_q <= 1'b1;
        end else begin
            unique case (op)
                OP_XCE: begin
                    e_q <= c_q;
                    c_q <= e_q;
                    if (enter_emu) begin
                        m_q <= 1'b1;
                        x_q <= 1'b1;
                    end
                end
                OP_REP: begin
                    c_q <= c_q & ~opnd[BIT_C];
                    if (!e_q) begin
                        m_q <= m_q & ~opnd[BIT_M];
                        x_q <= x_q & ~opnd[BIT_X];
                    end
                end
                OP_SEP: begin
                    c_q <= c_q | opnd[BIT_C];
                    if (!e_q) begin
                        m_q <= m_q | opnd[BIT_M];
                        x_q <= x_q | opnd[BIT_X];
                    end
                end
                OP_PLP: begin
                    c_q <= opnd[BIT_C];
                    if (!e_q) begin
                        m_q <= opnd[BIT_M];
                        x_q <= opnd[BIT_X];
                    end
                end
                default: ;
            endcase
        end
    end

    // Marks the cycle following a status update as MX-invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= (op == OP_REP) || (op == OP_SEP) || (op == OP_PLP);
    end

    assign mx_valid = !upd_q;
endmodule

// File: rtl/rsc_regfile.sv
// Word registers: accumulator, X, Y and stack pointer.
// Assumes: flags are the values before this cycle's update; one op per cycle.
module rsc_regfile
    import rsc_pkg::*;
#(
    parameter int               WORD_W    = 16,
    parameter logic [WORD_W-1:0] RESET_SP = 16'h01FF,
    parameter logic [WORD_W/2-1:0] EMU_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic              enter_emu,
    input  logic              flag_x,
    input  logic              flag_e,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] a_q,
    output logic [WORD_W-1:0] x_q,
    output logic [WORD_W-1:0] y_q,
    output logic [WORD_W-1:0] s_q
);
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] idx_wdata;
    logic [WORD_W-1:0] stk_wdata;
    logic              wr_act;

    assign wr_act    = (op == OP_WR);
    // Narrow index writes while X is set; stack page pinned in emulation.
    assign idx_wdata = flag_x ? {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]} : wr_data;
    assign stk_wdata = flag_e ? {EMU_PAGE, wr_data[BYTE_W-1:0]} : wr_data;

    // Accumulator: only plain writes touch it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         a_q <= '0;
        else if (wr_act && wr_sel == SEL_A) a_q <= wr_data;
    end

    // Index registers: writes, and high-byte clear on emulation entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (enter_emu) begin
            x_q[WORD_W-1:BYTE_W] <= '0;
            y_q[WORD_W-1:BYTE_W] <= '0;
        end else if (wr_act) begin
            if (wr_sel == SEL_X) x_q <= idx_wdata;
            if (wr_sel == SEL_Y) y_q <= idx_wdata;
        end
    end

    // Stack pointer: writes, and page forced on emulation entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                         s_q <= RESET_SP;
        else if (enter_emu)                 s_q[WORD_W-1:BYTE_W] <= EMU_PAGE;
        else if (wr_act && wr_sel == SEL_S) s_q <= stk_wdata;
    end
endmodule

// File: rtl/rsc_bank.sv
// Bank registers and the saved-program-bank push request.
// Assumes: flag_e is the mode before this cycle's update.
module rsc_bank
    import rsc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  op_e                 op,
    input  logic                flag_e,
    input  logic [2:0]          wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W/2-1:0] pbr_q,
    output logic [WORD_W/2-1:0] dbr_q,
    output logic                push_req,
    output logic [WORD_W/2-1:0] push_data
);
    localparam int BYTE_W = WORD_W / 2;

    logic unused_hi;
    assign unused_hi = ^wr_data[WORD_W-1:BYTE_W];

    // Program and data bank updates from writes and interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbr_q <= '0;
            dbr_q <= '0;
        end else if (op == OP_INT) begin
            pbr_q <= '0;
            if (flag_e) dbr_q <= '0;
        end else if (op == OP_WR) begin
            if (wr_sel == SEL_PB) pbr_q <= wr_data[BYTE_W-1:0];
            if (wr_sel == SEL_DB) dbr_q <= wr_data[BYTE_W-1:0];
        end
    end

    // One-cycle push request carrying the replaced program bank (native only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_req  <= 1'b0;
            push_data <= '0;
        end else begin
            push_req <= (op == OP_INT) && !flag_e;
            if ((op == OP_INT) && !flag_e) push_data <= pbr_q;
        end
    end
endmodule

// File: rtl/dual_mode_regstate.sv
// Top: architectural register state with native/emulation mode side effects.
// Assumes: commands are single-cycle strobes; collisions resolved by priority.
module dual_mode_regstate
    import rsc_pkg::*;
#(
    parameter int                  WORD_W   = 16,
    parameter logic [WORD_W-1:0]   RESET_SP = 16'h01FF,
    parameter logic [WORD_W/2-1:0] EMU_PAGE = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                int_cmd,
    input  logic                xce_cmd,
    input  logic                rep_cmd,
    input  logic                sep_cmd,
    input  logic                plp_cmd,
    input  logic [7:0]          stat_opnd,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   a_q,
    output logic [WORD_W-1:0]   x_q,
    output logic [WORD_W-1:0]   y_q,
    output logic [WORD_W-1:0]   s_q,
    output logic [WORD_W/2-1:0] pbr_q,
    output logic [WORD_W/2-1:0] dbr_q,
    output logic                flag_c,
    output logic                flag_m,
    output logic                flag_x,
    output logic                flag_e,
    output logic [1:0]          mx_bits,
    output logic                mx_valid,
    output logic                push_req,
    output logic [WORD_W/2-1:0] push_data
);
    op_e  op;
    logic enter_emu;

    rsc_cmd_decode u_dec (
        .int_cmd (int_cmd),
        .xce_cmd (xce_cmd),
        .rep_cmd (rep_cmd),
        .sep_cmd (sep_cmd),
        .plp_cmd (plp_cmd),
        .wr_en   (wr_en),
        .op      (op)
    );

    rsc_status #(.SB_W(8)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .opnd      (stat_opnd),
        .c_q       (flag_c),
        .m_q       (flag_m),
        .x_q       (flag_x),
        .e_q       (flag_e),
        .enter_emu (enter_emu),
        .mx_valid  (mx_valid)
    );

    rsc_regfile #(.WORD_W(WORD_W), .RESET_SP(RESET_SP), .EMU_PAGE(EMU_PAGE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .enter_emu (enter_emu),
        .flag_x    (flag_x),
        .flag_e    (flag_e),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .a_q       (a_q),
        .x_q       (x_q),
        .y_q       (y_q),
        .s_q       (s_q)
    );

    rsc_bank #(.WORD_W(WORD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .flag_e    (flag_e),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pbr_q     (pbr_q),
        .dbr_q     (dbr_q),
        .push_req  (push_req),
        .push_data (push_data)
    );

    // MX status output mirrors the width flags.
    assign mx_bits = {flag_m, flag_x};
endmodule

// File: rtl/rsc_chk.sv
// Property checker for dual_mode_regstate, attached by bind.
module rsc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        int_cmd,
    input logic        xce_cmd,
    input logic        rep_cmd,
    input logic        sep_cmd,
    input logic        plp_cmd,
    input logic [15:0] x_q,
    input logic [15:0] y_q,
    input logic [15:0] s_q,
    input logic [7:0]  pbr_q,
    input logic [7:0]  dbr_q,
    input logic        flag_c,
    input logic        flag_m,
    input logic        flag_x,
    input logic        flag_e,
    input logic [1:0]  mx_bits,
    input logic        mx_valid,
    input logic        push_req,
    input logic [7:0]  push_data
);
    // R6
    emu_mx_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_e |-> (flag_m && flag_x));
    // R3
    emu_stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_e |-> (s_q[15:8] == 8'h01));
    // R3
    emu_index_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_e |-> (x_q[15:8] == 8'h00 && y_q[15:8] == 8'h00));
    // R2
    xce_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xce_cmd && !int_cmd) |=> (flag_e == $past(flag_c) && flag_c == $past(flag_e)));
    // R8
    mx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rep_cmd || sep_cmd || plp_cmd) && !int_cmd && !xce_cmd) |=> !mx_valid);
    // R8
    mx_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mx_valid |=> (mx_valid || $past(rep_cmd || sep_cmd || plp_cmd)));
    // R8
    mx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mx_bits == {flag_m, flag_x});
    // R9
    push_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cmd && !flag_e) |=> (push_req && push_data == $past(pbr_q) && pbr_q == 8'h00));
    // R10
    int_emu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cmd && flag_e) |=> (!push_req && pbr_q == 8'h00 && dbr_q == 8'h00));
endmodule

bind dual_mode_regstate rsc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_cmd   (int_cmd),
    .xce_cmd   (xce_cmd),
    .rep_cmd   (rep_cmd),
    .sep_cmd   (sep_cmd),
    .plp_cmd   (plp_cmd),
    .x_q       (x_q),
    .y_q       (y_q),
    .s_q       (s_q),
    .pbr_q     (pbr_q),
    .dbr_q     (dbr_q),
    .flag_c    (flag_c),
    .flag_m    (flag_m),
    .flag_x    (flag_x),
    .flag_e    (flag_e),
    .mx_bits   (mx_bits),
    .mx_valid  (mx_valid),
    .push_req  (push_req),
    .push_data (push_data)
);

// File: tb/sim_dual_mode_regstate.sv
// Self-checking bench: directed corner cases plus seeded random commands,
// compared each cycle against a reference model written from the requirements.
module sim_dual_mode_regstate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_cmd = 0, xce_cmd = 0, rep_cmd = 0, sep_cmd = 0, plp_cmd = 0, wr_en = 0;
    logic [7:0]  stat_opnd = 0;
    logic [2:0]  wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] a_q, x_q, y_q, s_q;
    logic [7:0]  pbr_q, dbr_q, push_data;
    logic        flag_c, flag_m, flag_x, flag_e, mx_valid, push_req;
    logic [1:0]  mx_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    logic [15:0] ma, mx, my, ms;
    logic [7:0]  mpb, mdb, mpd;
    logic        mc, mm, mxf, me, mval, mpush;

    always #5 clk = ~clk;

    dual_mode_regstate u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        ma = 0; mx = 0; my = 0; ms = 16'h01FF; mpb = 0; mdb = 0; mpd = 0;
        mc = 0; mm = 1; mxf = 1; me = 1; mval = 1; mpush = 0;
    endtask

    // Applies the current strobes to the model, as one clock edge would.
    task automatic model_step();
        logic stat_op;
        stat_op = 0;
        mpush = 0;
        if (int_cmd) begin
            if (!me) begin mpush = 1; mpd = mpb; end
            else mdb = 0;
            mpb = 0;
        end else if (xce_cmd) begin
            if (!me && mc) begin
                mm = 1; mxf = 1; ms[15:8] = 8'h01; mx[15:8] = 0; my[15:8] = 0;
            end
            {me, mc} = {mc, me};
        end else if (rep_cmd) begin
            stat_op = 1; mc = mc & ~stat_opnd[0];
            if (!me) begin mm = mm & ~stat_opnd[5]; mxf = mxf & ~stat_opnd[4]; end
        end else if (sep_cmd) begin
            stat_op = 1; mc = mc | stat_opnd[0];
            if (!me) begin mm = mm | stat_opnd[5]; mxf = mxf | stat_opnd[4]; end
        end else if (plp_cmd) begin
            stat_op = 1; mc = stat_opnd[0];
            if (!me) begin mm = stat_opnd[5]; mxf = stat_opnd[4]; end
        end else if (wr_en) begin
            case (wr_sel)
                3'd0: ma = wr_data;
                3'd1: mx = mxf ? {8'h00, wr_data[7:0]} : wr_data;
                3'd2: my = mxf ? {8'h00, wr_data[7:0]} : wr_data;
                3'd3: ms = me ? {8'h01, wr_data[7:0]} : wr_data;
                3'd4: mpb = wr_data[7:0];
                3'd5: mdb = wr_data[7:0];
                default: ;
            endcase
        end
        mval = !stat_op;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " a"}, a_q, ma);
        chk({tag, " x"}, x_q, mx);
        chk({tag, " y"}, y_q, my);
        chk({tag, " s"}, s_q, ms);
        chk({tag, " pbr"}, {8'h0, pbr_q}, {8'h0, mpb});
        chk({tag, " dbr"}, {8'h0, dbr_q}, {8'h0, mdb});
        chk({tag, " flags cmxe"}, {12'h0, flag_c, flag_m, flag_x, flag_e}, {12'h0, mc, mm, mxf, me});
        chk({tag, " mx_bits"}, {14'h0, mx_bits}, {14'h0, mm, mxf});
        chk({tag, " mx_valid"}, {15'h0, mx_valid}, {15'h0, mval});
        chk({tag, " push_req"}, {15'h0, push_req}, {15'h0, mpush});
        if (mpush) chk({tag, " push_data"}, {8'h0, push_data}, {8'h0, mpd});
    endtask

    task automatic clear_in();
        int_cmd = 0; xce_cmd = 0; rep_cmd = 0; sep_cmd = 0; plp_cmd = 0; wr_en = 0;
    endtask

    // One clock: edge updates DUT and model, compare at the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
        clear_in();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d, input string tag);
        wr_en = 1; wr_sel = sel; wr_data = d; cyc(tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values, checked against constants
        chk("R1 a", a_q, 16'h0000);
        chk("R1 s", s_q, 16'h01FF);
        chk("R1 flags cmxe", {12'h0, flag_c, flag_m, flag_x, flag_e}, 16'h0007);
        chk("R1 banks", {pbr_q, dbr_q}, 16'h0000);
        chk("R1 mx_valid/push", {14'h0, mx_valid, push_req}, 16'h0002);
        rst_n = 1;
        cyc("R1 idle");
        // R4 leave emulation: C=0 -> E=0, C=1, M/X stay 1
        xce_cmd = 1; cyc("R4 R2 emu->native");
        // R5 clear M, X and C in native; R8 mx_valid drop
        stat_opnd = 8'h31; rep_cmd = 1; cyc("R5 R8 rep");
        cyc("R8 mx_valid recover");
        wr(3'd1, 16'hABCD, "R11 x wide");
        wr(3'd2, 16'h1234, "R11 y wide");
        wr(3'd3, 16'h5678, "R11 s native");
        wr(3'd0, 16'h9ABC, "R11 a");
        stat_opnd = 8'h10; sep_cmd = 1; cyc("R5 sep x");
        wr(3'd1, 16'hBEEF, "R11 x narrow");
        wr(3'd4, 16'h0012, "R11 pb");
        wr(3'd5, 16'h0034, "R11 db");
        wr(3'd7, 16'hFFFF, "R11 unused select");
        int_cmd = 1; cyc("R9 native int");
        cyc("R9 push ends");
        // R7 pull in native
        stat_opnd = 8'h20; plp_cmd = 1; cyc("R7 plp native");
        stat_opnd = 8'h01; sep_cmd = 1; cyc("R5 sep c");
        wr(3'd2, 16'h4321, "R11 y wide again");
        // R3 enter emulation
        xce_cmd = 1; cyc("R3 R2 native->emu");
        // R6 masked status in emulation
        stat_opnd = 8'h31; rep_cmd = 1; cyc("R6 rep emu");
        stat_opnd = 8'h00; plp_cmd = 1; cyc("R6 R8 plp emu");
        wr(3'd3, 16'hAA77, "R11 s emu");
        wr(3'd4, 16'h0055, "R11 pb emu");
        wr(3'd5, 16'h0066, "R11 db emu");
        int_cmd = 1; cyc("R10 emu int");
        cyc("R10 no push");
        // R12 collisions
        int_cmd = 1; wr_en = 1; wr_sel = 3'd0; wr_data = 16'h1111; cyc("R12 int over write");
        stat_opnd = 8'h01; rep_cmd = 1; sep_cmd = 1; cyc("R12 rep over sep");
        xce_cmd = 1; plp_cmd = 1; stat_opnd = 8'h01; cyc("R12 xce over plp");
        // Seeded random commands
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            int_cmd = (k == 0); xce_cmd = (k == 1) || (k == 2 && $urandom_range(0, 1) == 1);
            rep_cmd = (k == 3); sep_cmd = (k == 4); plp_cmd = (k == 5);
            wr_en = (k >= 5);
            stat_opnd = 8'($urandom); wr_sel = 3'($urandom); wr_data = 16'($urandom);
            cyc("R12 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule